// File: doc/BRIEF.md
# RAM Self-Test Controller

This block runs a built-in test over a window of an external single-port synchronous RAM. Software selects a test with an 8-bit command code, gives a start byte address and a length in bytes, and pulses a trigger. The controller then takes over the RAM port and runs one of two algorithms. The first is a two-pass write/readback check. The second is a six-element March-C sweep. The first failing location ends the test.

Progress shows on five outputs: a 16-bit state code, a ready flag, a 2-bit processing status, an interrupt flag, and the byte address of the first failure. The interrupt flag is raised each time the controller leaves idle and each time it returns to idle. Software clears the flag by pulsing a clear input.

The FSM has seven states. In `ST_IDLE` it waits for a command. In `ST_SETUP` it loads the word index for the current element. `ST_FWRITE` is the write issued before the read. `ST_READ` issues the read request. `ST_CHECK` compares the returned word. `ST_LWRITE` is the write issued after the compare. `ST_STEP` advances to the next address or the next element.

The transitions are:
- `ST_IDLE` goes to `ST_SETUP` when a valid command is accepted.
- `ST_SETUP` goes to `ST_IDLE` when the range holds no words. Otherwise it goes to `ST_FWRITE` or `ST_READ`.
- `ST_FWRITE` goes to `ST_READ` or `ST_STEP`.
- `ST_READ` goes to `ST_CHECK`.
- `ST_CHECK` goes to `ST_IDLE` on a mismatch. Otherwise it goes to `ST_LWRITE` or `ST_STEP`.
- `ST_LWRITE` goes to `ST_STEP`.
- `ST_STEP` goes to `ST_FWRITE` or `ST_READ` for the next address. At the end of an element it goes to `ST_SETUP`. After the last element it goes to `ST_IDLE`.

Top module: `ramtest_ctrl`

## Requirements
- R1: Command acceptance.
  - A trigger is accepted when it arrives with command code 0x02 or 0x03 while `ready` is 1.
  - The clock edge that samples an accepted trigger drops `ready` to 0.
  - From that edge until completion, `proc_status` reads 1 and `ready` stays 0.
- R2: Ignored triggers.
  - A trigger with any other command code does nothing.
  - A trigger that arrives while a test is running does nothing.
  - In both cases the state code, the test in progress and the RAM traffic are unchanged.
- R3: State code. `state_code` reads 0x0001 in idle, 0x0002 during the write/readback test and 0x0003 during the March-C test.
- R4: Interrupt flag.
  - `irq_flag` is set on the edge that leaves idle and on the edge that returns to idle.
  - A 1 on `irq_clr` clears the flag at the next edge.
  - When a set and a clear fall on the same edge, the set wins.
- R5: Write/readback test. The test makes two ascending passes over the word window.
  - In the first pass, each word is written with 0x55AA, then read and compared before the next address.
  - The second pass does the same with 0xAA55.
  - Word i sits at byte address start + 2*i.
- R6: March-C test. Six elements run in this order:
  - ascending write 0x0000;
  - ascending read 0x0000 then write 0xFFFF;
  - ascending read 0xFFFF then write 0x0000;
  - descending read 0x0000 then write 0xFFFF;
  - descending read 0xFFFF then write 0x0000;
  - ascending read 0x0000.
- R7: Window size. The window holds size_bytes/2 words, rounded down. A window of zero words passes at once with status 2 and issues no RAM access.
- R8: Result status. `proc_status` is 0 after reset. On completion it is 2 if every compare matched and 3 if one did not.
- R9: Failure address. The first mismatch ends the test. `fail_addr` then holds the byte address of the failing word. `fail_addr` changes only on a mismatch, and reads 0 after reset.
- R10: Read timing. The word on `mem_rdata` is compared in the cycle after the read request. The RAM is touched only while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_code | input | 8 | Test select: 0x02 write/readback, 0x03 March-C |
| start_addr | input | 32 | Byte address of the first word |
| size_bytes | input | 32 | Window length in bytes |
| trigger | input | 1 | One-cycle command issue pulse |
| irq_clr | input | 1 | Clears the interrupt flag |
| state_code | output | 16 | Visible state: 1 idle, 2 write/readback, 3 March-C |
| ready | output | 1 | Command can be accepted |
| proc_status | output | 2 | 0 reset, 1 running, 2 pass, 3 fail |
| irq_flag | output | 1 | Interrupt flag |
| fail_addr | output | 32 | Byte address of the first mismatch |
| mem_req | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 32 | RAM byte address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, valid one cycle after a read |

## Verification
Two events can coincide on the interrupt flag: the flag being set as the controller returns to idle, and software clearing it. To provoke this, the bench holds `irq_clr` high from the cycle after a write/readback test is accepted until `ready` rises again. The flag must read 0 during the run and 1 once idle is reached, which shows that the set won the collision. A second overlap is a trigger pulse arriving mid-test. It is judged by the state code and the read count, which must match an undisturbed run.

// File: rtl/ramtest_pkg.sv
`timescale 1ns/1ps
package ramtest_pkg;

    localparam int unsigned RT_DW = 16;

    localparam logic [RT_DW-1:0] PAT_LO   = {(RT_DW/16){16'h55AA}};
    localparam logic [RT_DW-1:0] PAT_HI   = {(RT_DW/16){16'hAA55}};
    localparam logic [RT_DW-1:0] ALL_ZERO = '0;
    localparam logic [RT_DW-1:0] ALL_ONE  = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FWRITE,
        ST_READ,
        ST_CHECK,
        ST_LWRITE,
        ST_STEP
    } rt_state_e;

    // What one sweep over the window does at each address
    typedef struct packed {
        logic             first_wr;
        logic             rd_chk;
        logic             late_wr;
        logic             desc;
        logic             last;
        logic [RT_DW-1:0] expect_w;
        logic [RT_DW-1:0] write_w;
    } rt_elem_t;

    function automatic rt_elem_t rt_elem(input logic march, input logic [2:0] idx);
        rt_elem_t e;
        e = '0;
        if (!march) begin
            e.first_wr = 1'b1;
            e.rd_chk   = 1'b1;
            e.last     = (idx == 3'd1);
            e.write_w  = (idx == 3'd0) ? PAT_LO : PAT_HI;
            e.expect_w = e.write_w;
        end else begin
            unique case (idx)
                3'd0: begin e.first_wr = 1'b1; e.write_w = ALL_ZERO; end
                3'd1: begin e.rd_chk = 1'b1; e.expect_w = ALL_ZERO; e.late_wr = 1'b1; e.write_w = ALL_ONE; end
                3'd2: begin e.rd_chk = 1'b1; e.expect_w = ALL_ONE; e.late_wr = 1'b1; e.write_w = ALL_ZERO; end
                3'd3: begin e.desc = 1'b1; e.rd_chk = 1'b1; e.expect_w = ALL_ZERO; e.late_wr = 1'b1; e.write_w = ALL_ONE; end
                3'd4: begin e.desc = 1'b1; e.rd_chk = 1'b1; e.expect_w = ALL_ONE; e.late_wr = 1'b1; e.write_w = ALL_ZERO; end
                default: begin e.rd_chk = 1'b1; e.expect_w = ALL_ZERO; e.last = 1'b1; end
            endcase
        end
        return e;
    endfunction

endpackage

// File: rtl/rt_index_ctr.sv
`timescale 1ns/1ps
module rt_index_ctr #(
    parameter int unsigned AW  = 32,
    parameter int unsigned BPW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_cfg,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] size_in,
    input  logic          start_elem,
    input  logic          advance,
    input  logic          desc,
    output logic [AW-1:0] addr,
    output logic          at_end,
    output logic          empty
);
    localparam int unsigned SHIFT = $clog2(BPW);

    logic [AW-1:0] base_q;
    logic [AW-1:0] words_q;
    logic [AW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            words_q <= '0;
            idx_q   <= '0;
        end else begin
            if (load_cfg) begin
                base_q  <= base_in;
                words_q <= size_in >> SHIFT;
            end
            if (start_elem) begin
                idx_q <= desc ? (words_q - 1'b1) : '0;
            end else if (advance) begin
                idx_q <= desc ? (idx_q - 1'b1) : (idx_q + 1'b1);
            end
        end
    end

    assign empty  = (words_q == '0);
    assign at_end = desc ? (idx_q == '0) : (idx_q == words_q - 1'b1);
    assign addr   = base_q + (idx_q << SHIFT);

endmodule

// File: rtl/rt_irq_flag.sv
`timescale 1ns/1ps
module rt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;   // set beats clear
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/ramtest_ctrl.sv
`timescale 1ns/1ps
module ramtest_ctrl
    import ramtest_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter logic [7:0]  CMD_RW    = 8'h02,
    parameter logic [7:0]  CMD_MARCH = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cmd_code,
    input  logic [AW-1:0]    start_addr,
    input  logic [AW-1:0]    size_bytes,
    input  logic             trigger,
    input  logic             irq_clr,
    output logic [15:0]      state_code,
    output logic             ready,
    output logic [1:0]       proc_status,
    output logic             irq_flag,
    output logic [AW-1:0]    fail_addr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [RT_DW-1:0] mem_wdata,
    input  logic [RT_DW-1:0] mem_rdata
);
    localparam int unsigned BPW = RT_DW / 8;

    rt_state_e     state_q, state_d;
    logic [2:0]    elem_q;
    logic          march_q;
    logic [1:0]    status_q;
    logic [AW-1:0] fail_q;
    rt_elem_t      einfo;
    logic          accept, mismatch, finish_ok;
    logic [AW-1:0] cur_addr;
    logic          at_end, empty;

    assign einfo     = rt_elem(march_q, elem_q);
    assign accept    = (state_q == ST_IDLE) && trigger &&
                       ((cmd_code == CMD_RW) || (cmd_code == CMD_MARCH));
    assign mismatch  = (state_q == ST_CHECK) && (mem_rdata != einfo.expect_w);
    assign finish_ok = ((state_q == ST_SETUP) && empty) ||
                       ((state_q == ST_STEP) && at_end && einfo.last);

    rt_index_ctr #(.AW(AW), .BPW(BPW)) u_idx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cfg   (accept),
        .base_in    (start_addr),
        .size_in    (size_bytes),
        .start_elem (state_q == ST_SETUP),
        .advance    ((state_q == ST_STEP) && !at_end),
        .desc       (einfo.desc),
        .addr       (cur_addr),
        .at_end     (at_end),
        .empty      (empty)
    );

    rt_irq_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ((state_q == ST_IDLE) != (state_d == ST_IDLE)),
        .clr_i  (irq_clr),
        .flag_o (irq_flag)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  if (empty)  state_d = ST_IDLE;
                       else        state_d = einfo.first_wr ? ST_FWRITE : ST_READ;
            ST_FWRITE: state_d = einfo.rd_chk ? ST_READ : ST_STEP;
            ST_READ:   state_d = ST_CHECK;
            ST_CHECK:  if (mismatch) state_d = ST_IDLE;
                       else          state_d = einfo.late_wr ? ST_LWRITE : ST_STEP;
            ST_LWRITE: state_d = ST_STEP;
            ST_STEP:   if (at_end) state_d = einfo.last ? ST_IDLE : ST_SETUP;
                       else        state_d = einfo.first_wr ? ST_FWRITE : ST_READ;
            default:   state_d = ST_IDLE;
        endcase
    end

    // registered outputs and test context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem_q   <= '0;
            march_q  <= 1'b0;
            status_q <= 2'd0;
            fail_q   <= '0;
        end else begin
            if (accept) begin
                march_q  <= (cmd_code == CMD_MARCH);
                elem_q   <= '0;
                status_q <= 2'd1;
            end
            if (mismatch) begin
                status_q <= 2'd3;
                fail_q   <= cur_addr;
            end
            if (finish_ok) status_q <= 2'd2;
            if ((state_q == ST_STEP) && at_end && !einfo.last) elem_q <= elem_q + 3'd1;
        end
    end

    assign ready       = (state_q == ST_IDLE);
    assign state_code  = ready ? 16'h0001 : (march_q ? 16'h0003 : 16'h0002);
    assign proc_status = status_q;
    assign fail_addr   = fail_q;
    assign mem_req     = (state_q == ST_FWRITE) || (state_q == ST_READ) || (state_q == ST_LWRITE);
    assign mem_we      = (state_q == ST_FWRITE) || (state_q == ST_LWRITE);
    assign mem_addr    = cur_addr;
    assign mem_wdata   = einfo.write_w;

endmodule

// File: rtl/ramtest_ctrl_checker.sv
`timescale 1ns/1ps
module ramtest_ctrl_checker #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   state_code,
    input logic          ready,
    input logic [1:0]    proc_status,
    input logic          irq_flag,
    input logic [AW-1:0] fail_addr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata
);
    a_r1_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> proc_status == 2'd1);
    a_r3_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> state_code == 16'h0001);
    a_r3_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (state_code == 16'h0002 || state_code == 16'h0003));
    a_r2_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> $stable(state_code));
    a_r4_irq_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> irq_flag);
    a_r4_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> irq_flag);
    a_r5_rw_patterns: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state_code == 16'h0002) |->
            (mem_wdata == {(DW/16){16'h55AA}} || mem_wdata == {(DW/16){16'hAA55}}));
    a_r6_march_patterns: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state_code == 16'h0003) |-> (mem_wdata == '0 || mem_wdata == '1));
    a_r8_done_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (proc_status == 2'd2 || proc_status == 2'd3));
    a_r9_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && proc_status == 2'd2) |-> $stable(fail_addr));
    a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ready);
endmodule

bind ramtest_ctrl ramtest_ctrl_checker #(.AW(AW), .DW(ramtest_pkg::RT_DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_code  (state_code),
    .ready       (ready),
    .proc_status (proc_status),
    .irq_flag    (irq_flag),
    .fail_addr   (fail_addr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata)
);

// File: tb/ramtest_ctrl_bench.sv
`timescale 1ns/1ps
module ramtest_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [31:0] start_addr = '0;
    logic [31:0] size_bytes = '0;
    logic        trigger = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] state_code;
    logic        ready;
    logic [1:0]  proc_status;
    logic        irq_flag;
    logic [31:0] fail_addr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ramtest_ctrl u_ramtest_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .start_addr(start_addr),
        .size_bytes(size_bytes), .trigger(trigger), .irq_clr(irq_clr),
        .state_code(state_code), .ready(ready), .proc_status(proc_status),
        .irq_flag(irq_flag), .fail_addr(fail_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // RAM model: 64 words, one-cycle read, optional stuck-at-0 on bit 0
    logic [15:0] ram [0:63];
    logic        fault_en = 1'b0;
    logic [5:0]  fault_idx = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] rd_log [0:511];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                ram[mem_addr[6:1]] <= (fault_en && mem_addr[6:1] == fault_idx) ?
                                      (mem_wdata & 16'hFFFE) : mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= ram[mem_addr[6:1]];
                rd_log[rd_cnt[8:0]] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [15:0] v);
        @(negedge clk);
        for (int i = 0; i < 64; i++) ram[i] <= v;
    endtask

    task automatic issue(input logic [7:0] c, input logic [31:0] a, input logic [31:0] s);
        @(negedge clk);
        cmd_code = c; start_addr = a; size_bytes = s; trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8", "reset ready", {31'd0, ready}, 32'd1);
        chk("R3", "reset state", {16'd0, state_code}, 32'h1);
        chk("R8", "reset status", {30'd0, proc_status}, 32'd0);
        chk("R4", "reset irq", {31'd0, irq_flag}, 32'd0);
        chk("R9", "reset fail_addr", fail_addr, 32'd0);
        chk("R10", "reset mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_rw_pass();
        int b;
        fill(16'h1234);
        b = rd_cnt;
        issue(8'h02, 32'h20, 32'd16);
        chk("R1", "ready drops", {31'd0, ready}, 32'd0);
        chk("R1", "status running", {30'd0, proc_status}, 32'd1);
        chk("R3", "rw state code", {16'd0, state_code}, 32'h2);
        chk("R4", "irq on start", {31'd0, irq_flag}, 32'd1);
        clear_irq();
        chk("R4", "irq cleared", {31'd0, irq_flag}, 32'd0);
        wait_ready();
        chk("R4", "irq on finish", {31'd0, irq_flag}, 32'd1);
        chk("R8", "rw pass status", {30'd0, proc_status}, 32'd2);
        chk("R5", "rw read count", rd_cnt - b, 32'd16);
        for (int k = 0; k < 16; k++)
            chk("R5", "rw read order", rd_log[b + k], 32'h20 + 2 * (k % 8));
        for (int i = 16; i < 24; i++) chk("R5", "rw final data", {16'd0, ram[i]}, 32'hAA55);
        chk("R5", "rw outside untouched", {16'd0, ram[24]}, 32'h1234);
        clear_irq();
    endtask

    task automatic t_march_pass();
        int b, w, k;
        fill(16'h1234);
        b = rd_cnt; w = wr_cnt;
        issue(8'h03, 32'h10, 32'd17);   // 17 bytes -> 8 words (R7)
        chk("R3", "march state code", {16'd0, state_code}, 32'h3);
        wait_ready();
        chk("R8", "march pass status", {30'd0, proc_status}, 32'd2);
        chk("R6", "march read count", rd_cnt - b, 32'd40);
        chk("R6", "march write count", wr_cnt - w, 32'd40);
        k = 0;
        for (int e = 1; e <= 5; e++)
            for (int i = 0; i < 8; i++) begin
                chk("R6", "march read order", rd_log[b + k],
                    32'h10 + 2 * ((e == 3 || e == 4) ? (7 - i) : i));
                k++;
            end
        for (int i = 8; i < 16; i++) chk("R6", "march final data", {16'd0, ram[i]}, 32'h0);
        chk("R7", "odd byte not tested", {16'd0, ram[16]}, 32'h1234);
        clear_irq();
    endtask

    task automatic t_rw_fail();
        int b;
        fill(16'h0000);
        fault_en = 1'b1; fault_idx = 6'd11;
        b = rd_cnt;
        issue(8'h02, 32'h10, 32'd16);
        wait_ready();
        chk("R8", "rw fail status", {30'd0, proc_status}, 32'd3);
        chk("R9", "rw fail addr", fail_addr, 32'h16);
        chk("R9", "rw stops at fault", rd_cnt - b, 32'd12);
        fault_en = 1'b0;
        clear_irq();
    endtask

    task automatic t_march_fail();
        int b;
        fill(16'h0000);
        fault_en = 1'b1; fault_idx = 6'd13;
        b = rd_cnt;
        issue(8'h03, 32'h10, 32'd16);
        wait_ready();
        chk("R8", "march fail status", {30'd0, proc_status}, 32'd3);
        chk("R9", "march fail addr", fail_addr, 32'h1A);
        chk("R9", "march stops at fault", rd_cnt - b, 32'd14);
        fault_en = 1'b0;
        clear_irq();
        // a later passing run must not disturb the captured address
        issue(8'h02, 32'h20, 32'd4);
        wait_ready();
        chk("R9", "fail addr held after pass", fail_addr, 32'h1A);
        clear_irq();
    endtask

    task automatic t_size_zero();
        int b, w;
        b = rd_cnt; w = wr_cnt;
        issue(8'h03, 32'h10, 32'd1);
        chk("R7", "zero size enters test", {31'd0, ready}, 32'd0);
        @(negedge clk);
        chk("R7", "zero size done", {31'd0, ready}, 32'd1);
        chk("R7", "zero size status", {30'd0, proc_status}, 32'd2);
        chk("R7", "zero size no access", (rd_cnt - b) + (wr_cnt - w), 32'd0);
        clear_irq();
    endtask

    task automatic t_ignore();
        int b;
        issue(8'h05, 32'h10, 32'd16);
        chk("R2", "bad code ready", {31'd0, ready}, 32'd1);
        chk("R2", "bad code state", {16'd0, state_code}, 32'h1);
        chk("R2", "bad code irq", {31'd0, irq_flag}, 32'd0);
        b = rd_cnt;
        issue(8'h02, 32'h20, 32'd16);
        repeat (5) @(negedge clk);
        issue(8'h03, 32'h10, 32'd8);
        chk("R2", "busy trigger state", {16'd0, state_code}, 32'h2);
        wait_ready();
        chk("R2", "busy trigger reads", rd_cnt - b, 32'd16);
        chk("R2", "busy trigger status", {30'd0, proc_status}, 32'd2);
        clear_irq();
    endtask

    task automatic t_irq_collision();
        issue(8'h02, 32'h20, 32'd16);
        irq_clr = 1'b1;
        @(negedge clk);
        chk("R4", "clear during run", {31'd0, irq_flag}, 32'd0);
        wait_ready();
        chk("R4", "set wins over clear", {31'd0, irq_flag}, 32'd1);
        irq_clr = 1'b0;
        @(negedge clk);
        chk("R4", "flag kept after release", {31'd0, irq_flag}, 32'd1);
        clear_irq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw_pass();
        t_march_pass();
        t_rw_fail();
        t_march_fail();
        t_size_zero();
        t_ignore();
        t_irq_collision();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule